// File: doc/BRIEF.md
# Front-Panel Control Word with Memory-Mode Latch

This block is one 16-bit location on a word-addressed processor bus. A write sets a set of panel outputs: the control and data lines of a character display, an error lamp, a three-bit keyboard row address and one general output. A read returns the display byte, five keyboard column lines, two push buttons and one spare input. The keyboard row address is decoded into eight active-low row strobes. These strobes come from flops and carry no glitch path from the bus.

The same location also hides a four-bit memory-mode latch. A write loads this latch only when the word has the display enable clear, the register-select clear and the top bit set. Every other write to the location changes the panel outputs and leaves the memory mode unchanged. Firmware uses this to switch memory maps through the display port.

Top module: `panel_ctl`

## Requirements
- R1: Only `bus_addr` equal to 16'hFF00 reaches the block. A write to any other address leaves every output unchanged.
- R2: A write at the port address is visible on the outputs after the next rising clock edge. The word maps as follows: bits 7..0 go to `lcd_d_out`, bit 8 to `led_err`, bit 9 to `lcd_rs`, bit 10 to `lcd_rw`, bit 11 to `lcd_en` and bit 15 to `extra_out`.
- R3: An asynchronous reset (`rst_n` low) clears the control word to zero and sets `bank_mode` to 0. It also gives `row_sel_n`=8'hFE and `lcd_d_oe`=1.
- R4: `lcd_d_oe` is 1 exactly while the stored bit 10 is 0. While it is 0, read bits 7..0 return `lcd_d_in`. While it is 1, they return the stored byte.
- R5: Word bits 14..12 hold a row index k. `row_sel_n` has bit k low and all other bits high, and it updates on the same edge as the control word.
- R6: On a read at the port address, bits 12..8 return the inverse of `kb_n[4:0]`, bits 13 and 14 return the inverse of `btn_n[0]` and `btn_n[1]`, and bit 15 returns `spare_in` uninverted.
- R7: Each of the inputs `kb_n`, `btn_n` and `spare_in` passes through two flops. A change at one of these inputs appears in `bus_rdata` after the second rising edge, and does not appear after the first.
- R8: A port write with bit 11=0, bit 9=0 and bit 15=1 loads bits 3..0 into `bank_mode` at the next edge. Bits 5..4 of that word have no effect on `bank_mode`.
- R9: A port write that fails the R8 condition still updates the control word and `row_sel_n`, and `bank_mode` keeps its value.
- R10: `bus_rdata` is zero whenever `bus_rd` is low or the address does not match.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_addr | input | 16 | Bus address |
| bus_wr | input | 1 | Write strobe, one cycle |
| bus_rd | input | 1 | Read strobe |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data, zero when not selected |
| lcd_d_out | output | 8 | Display data out |
| lcd_d_oe | output | 1 | Display data output enable |
| lcd_d_in | input | 8 | Display data in from the pad |
| lcd_rs | output | 1 | Display register select |
| lcd_rw | output | 1 | Display read/write |
| lcd_en | output | 1 | Display enable |
| led_err | output | 1 | Error lamp |
| extra_out | output | 1 | General output (word bit 15) |
| row_sel_n | output | 8 | Keyboard row strobes, active low |
| kb_n | input | 5 | Keyboard column lines, active low |
| btn_n | input | 2 | Push buttons, active low |
| spare_in | input | 1 | Spare input |
| bank_mode | output | 4 | Memory-mode latch |

## Verification
The hardest behaviour to reach is a write that almost loads the memory mode: the word has bit 15 set but only one of the enable or register-select bits clear. Such a write must move every panel output and leave `bank_mode` alone. The vector table places these near-miss words between qualifying words that load different mode values, so a held value can be told apart from a reloaded one. A qualifying word with bits 5..4 set checks that only the low nibble is taken. The synchronizer depth is tested by sampling `bus_rdata` once after the first edge and once after the second edge that follow an input change.

// File: rtl/panel_ctl_pkg.sv
package panel_ctl_pkg;
    localparam int WORD_W    = 16;
    localparam int BYTE_W    = 8;
    localparam int BIT_LED   = 8;
    localparam int BIT_RS    = 9;
    localparam int BIT_RW    = 10;
    localparam int BIT_EN    = 11;
    localparam int ROW_LSB   = 12;
    localparam int ROW_W     = 3;
    localparam int ROWS      = 1 << ROW_W;
    localparam int BIT_EXTRA = 15;
    localparam int BANK_W    = 4;
    localparam int KB_W      = 5;
    localparam int BTN_W     = 2;

    typedef struct packed {
        logic [WORD_W-1:0] word;
        logic [ROWS-1:0]   rows_n;
        logic [BANK_W-1:0] bank;
    } panel_state_t;
endpackage

// File: rtl/panel_sync.sv
module panel_sync #(
    parameter int          WIDTH     = 1,
    parameter int          STAGES    = 2,
    parameter logic        RESET_VAL = 1'b0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_i,
    output logic [WIDTH-1:0] sync_o
);
    for (genvar b = 0; b < WIDTH; b++) begin : g_bit
        logic [STAGES-1:0] chain_q;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain_q <= {STAGES{RESET_VAL}};
            else        chain_q <= {chain_q[STAGES-2:0], async_i[b]};
        end
        assign sync_o[b] = chain_q[STAGES-1];
    end
endmodule

// File: rtl/panel_row_dec.sv
module panel_row_dec #(
    parameter int SEL_W = 3,
    localparam int N    = 1 << SEL_W
) (
    input  logic [SEL_W-1:0] idx_i,
    output logic [N-1:0]     sel_n_o
);
    for (genvar i = 0; i < N; i++) begin : g_row
        assign sel_n_o[i] = (idx_i != SEL_W'(i));
    end
endmodule

// File: rtl/panel_bank_qual.sv
module panel_bank_qual
    import panel_ctl_pkg::*;
(
    input  logic [WORD_W-1:0] word_i,
    output logic              load_o
);
    always_comb begin
        load_o = word_i[BIT_EXTRA] & ~word_i[BIT_EN] & ~word_i[BIT_RS];
    end
endmodule

// File: rtl/panel_ctl.sv
module panel_ctl
    import panel_ctl_pkg::*;
#(
    parameter logic [15:0] PORT_ADDR = 16'hFF00,
    parameter int          SYNC_N    = 2
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic [15:0] bus_addr,
    input  logic        bus_wr,
    input  logic        bus_rd,
    input  logic [15:0] bus_wdata,
    output logic [15:0] bus_rdata,
    output logic [7:0]  lcd_d_out,
    output logic        lcd_d_oe,
    input  logic [7:0]  lcd_d_in,
    output logic        lcd_rs,
    output logic        lcd_rw,
    output logic        lcd_en,
    output logic        led_err,
    output logic        extra_out,
    output logic [7:0]  row_sel_n,
    input  logic [4:0]  kb_n,
    input  logic [1:0]  btn_n,
    input  logic        spare_in,
    output logic [3:0]  bank_mode
);
    panel_state_t st_d, st_q;
    logic         hit;
    logic         bank_load;
    logic [ROWS-1:0]  rows_next_n;
    logic [KB_W-1:0]  kb_s_n;
    logic [BTN_W-1:0] btn_s_n;
    logic             spare_s;

    assign hit = (bus_addr == PORT_ADDR);

    panel_bank_qual u_qual (
        .word_i (bus_wdata),
        .load_o (bank_load)
    );

    panel_row_dec #(.SEL_W(ROW_W)) u_dec (
        .idx_i   (bus_wdata[ROW_LSB +: ROW_W]),
        .sel_n_o (rows_next_n)
    );

    panel_sync #(.WIDTH(KB_W), .STAGES(SYNC_N), .RESET_VAL(1'b1)) u_sync_kb (
        .clk (clk), .rst_n (rst_n), .async_i (kb_n), .sync_o (kb_s_n)
    );
    panel_sync #(.WIDTH(BTN_W), .STAGES(SYNC_N), .RESET_VAL(1'b1)) u_sync_btn (
        .clk (clk), .rst_n (rst_n), .async_i (btn_n), .sync_o (btn_s_n)
    );
    panel_sync #(.WIDTH(1), .STAGES(SYNC_N), .RESET_VAL(1'b0)) u_sync_spare (
        .clk (clk), .rst_n (rst_n), .async_i (spare_in), .sync_o (spare_s)
    );

    // next-state: word and row strobes move together; the bank moves only on a qualified write
    always_comb begin
        st_d = st_q;
        if (bus_wr && hit) begin
            st_d.word   = bus_wdata;
            st_d.rows_n = rows_next_n;
            if (bank_load) st_d.bank = bus_wdata[BANK_W-1:0];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.word   <= '0;
            st_q.rows_n <= {{(ROWS-1){1'b1}}, 1'b0};
            st_q.bank   <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign lcd_d_out = st_q.word[BYTE_W-1:0];
    assign lcd_d_oe  = ~st_q.word[BIT_RW];
    assign lcd_rs    = st_q.word[BIT_RS];
    assign lcd_rw    = st_q.word[BIT_RW];
    assign lcd_en    = st_q.word[BIT_EN];
    assign led_err   = st_q.word[BIT_LED];
    assign extra_out = st_q.word[BIT_EXTRA];
    assign row_sel_n = st_q.rows_n;
    assign bank_mode = st_q.bank;

    always_comb begin
        bus_rdata = '0;
        if (bus_rd && hit) begin
            bus_rdata[BYTE_W-1:0] = st_q.word[BIT_RW] ? lcd_d_in : st_q.word[BYTE_W-1:0];
            bus_rdata[12:8]       = ~kb_s_n;
            bus_rdata[14:13]      = ~btn_s_n;
            bus_rdata[15]         = spare_s;
        end
    end

    // R5: exactly one row strobe low at all times after reset
    a_r5_row_onehot: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(~row_sel_n) == 1);

    // R1/R2: no port write, no change on the panel outputs
    a_r1_hold_outputs: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_wr && bus_addr == PORT_ADDR) |=> $stable({lcd_d_out, lcd_rs, lcd_rw, lcd_en, led_err, extra_out, row_sel_n}));

    // R8: qualified write loads the low nibble
    a_r8_bank_load: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == PORT_ADDR && bus_wdata[15] && !bus_wdata[11] && !bus_wdata[9])
        |=> bank_mode == $past(bus_wdata[3:0]));

    // R9: anything else leaves the bank alone
    a_r9_bank_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_wr && bus_addr == PORT_ADDR && bus_wdata[15] && !bus_wdata[11] && !bus_wdata[9])
        |=> $stable(bank_mode));

    // R2: a port write appears on the outputs one edge later
    a_r2_write_map: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == PORT_ADDR) |=> {extra_out, lcd_en, lcd_rw, lcd_rs, led_err, lcd_d_out} ==
            {$past(bus_wdata[15]), $past(bus_wdata[11:0])});

    // R10: idle read bus
    a_r10_rdata_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_rd && bus_addr == PORT_ADDR) |-> bus_rdata == 16'h0000);
endmodule

// File: tb/panel_ctl_bench.sv
module panel_ctl_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] bus_addr = 16'h0;
    logic        bus_wr = 1'b0;
    logic        bus_rd = 1'b0;
    logic [15:0] bus_wdata = 16'h0;
    logic [15:0] bus_rdata;
    logic [7:0]  lcd_d_out;
    logic        lcd_d_oe;
    logic [7:0]  lcd_d_in = 8'h00;
    logic        lcd_rs, lcd_rw, lcd_en, led_err, extra_out;
    logic [7:0]  row_sel_n;
    logic [4:0]  kb_n = 5'h1F;
    logic [1:0]  btn_n = 2'b11;
    logic        spare_in = 1'b0;
    logic [3:0]  bank_mode;

    int checks = 0;
    int failures = 0;
    int cycles = 0;
    bit finished = 0;

    localparam logic [15:0] PORT = 16'hFF00;

    always #4 clk = ~clk;

    panel_ctl u_panel_ctl (
        .clk, .rst_n, .bus_addr, .bus_wr, .bus_rd, .bus_wdata, .bus_rdata,
        .lcd_d_out, .lcd_d_oe, .lcd_d_in, .lcd_rs, .lcd_rw, .lcd_en, .led_err,
        .extra_out, .row_sel_n, .kb_n, .btn_n, .spare_in, .bank_mode
    );

    // {write word, expected bank after, expected row strobes}
    localparam int NV = 8;
    localparam logic [27:0] VEC [NV] = '{
        {16'h8005, 4'h5, 8'hFE},
        {16'h0A3C, 4'h5, 8'hFE},
        {16'h8A07, 4'h5, 8'hFE},
        {16'h823F, 4'h5, 8'hFE},
        {16'hF03A, 4'hA, 8'h7F},
        {16'h5433, 4'hA, 8'hDF},
        {16'hB10F, 4'hF, 8'hF7},
        {16'hA000, 4'h0, 8'hFB}
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [15:0] a, input logic [15:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0; bus_addr = 16'h0;
    endtask

    task automatic rd(input logic [15:0] a, output logic [15:0] d);
        bus_addr = a; bus_rd = 1'b1;
        #1 d = bus_rdata;
        bus_rd = 1'b0; bus_addr = 16'h0;
    endtask

    task automatic check_word(input string req, input logic [15:0] w);
        check(req, {24'h0, lcd_d_out}, {24'h0, w[7:0]});
        check(req, {27'h0, extra_out, lcd_en, lcd_rw, lcd_rs, led_err},
                   {27'h0, w[15], w[11], w[10], w[9], w[8]});
        check(req, {31'h0, lcd_d_oe}, {31'h0, ~w[10]});
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 20000) begin
            failures++;
            checks++;
            $display("FAIL watchdog actual=%0d expected<=20000", cycles);
            finish_run();
        end
    end

    initial begin
        logic [15:0] r;
        repeat (3) @(negedge clk);
        // R3 reset state
        check("R3 word", {16'h0, lcd_d_out, extra_out, lcd_en, lcd_rw, lcd_rs, led_err, 3'b0}, 32'h0);
        check("R3 rows", {24'h0, row_sel_n}, 32'hFE);
        check("R3 bank", {28'h0, bank_mode}, 32'h0);
        check("R3 oe", {31'h0, lcd_d_oe}, 32'h1);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 other address ignored
        wr(16'hFF02, 16'hB5FF);
        check_word("R1 miss", 16'h0000);
        check("R1 rows", {24'h0, row_sel_n}, 32'hFE);
        check("R1 bank", {28'h0, bank_mode}, 32'h0);

        // table: R2 R5 R8 R9
        for (int i = 0; i < NV; i++) begin
            wr(PORT, VEC[i][27:12]);
            check_word("R2 map", VEC[i][27:12]);
            check("R5 rows", {24'h0, row_sel_n}, {24'h0, VEC[i][7:0]});
            check("R8/R9 bank", {28'h0, bank_mode}, {28'h0, VEC[i][11:8]});
        end

        // R10: reads of other address or without strobe
        @(negedge clk);
        rd(16'hFF01, r);
        check("R10 miss", {16'h0, r}, 32'h0);
        #1 check("R10 idle", {16'h0, bus_rdata}, 32'h0);

        // R4 store byte read back while driving
        wr(PORT, 16'h0055);
        lcd_d_in = 8'hC3;
        @(negedge clk);
        rd(PORT, r);
        check("R4 driven byte", {24'h0, r[7:0]}, 32'h55);
        wr(PORT, 16'h0455);
        check("R4 oe off", {31'h0, lcd_d_oe}, 32'h0);
        @(negedge clk);
        rd(PORT, r);
        check("R4 pad byte", {24'h0, r[7:0]}, 32'hC3);

        // R6 R7 input map and two-edge latency
        @(negedge clk);
        rd(PORT, r);
        check("R6 idle inputs", {16'h0, r[15:8]}, 32'h00);
        kb_n = 5'b10110; btn_n = 2'b01; spare_in = 1'b1;
        @(negedge clk);
        rd(PORT, r);
        check("R7 after one edge", {16'h0, r[15:8]}, 32'h00);
        @(negedge clk);
        rd(PORT, r);
        check("R7 after two edges", {16'h0, r[15:8]}, 32'hC9);
        check("R6 map", {27'h0, r[12:8]}, 32'h09);

        // R3 reset in mid-run clears bank and word
        wr(PORT, 16'hF807);
        wr(PORT, 16'h8006);
        check("R8 second load", {28'h0, bank_mode}, 32'h6);
        #1 rst_n = 1'b0;
        #2 check("R3 async bank", {28'h0, bank_mode}, 32'h0);
        check("R3 async rows", {24'h0, row_sel_n}, 32'hFE);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        finish_run();
    end
endmodule